// File: doc/BRIEF.md
# Byte-Lane Write Decoder

This block sits in front of the storage array of a synchronous SRAM. It takes the active-low write controls: a global write strobe, a byte-write enable and one select line per byte lane. On each rising clock edge it registers them together with the address and write data. From the registered values it produces one write enable per byte lane, a flag that says a write is under way, and a bit-level write mask. The array applies the mask in the cycle after the controls were sampled.

Each byte lane is 9 bits wide: 8 data bits and 1 parity bit. Lane k covers data bits 9k+8 down to 9k. The default build is 36 bits wide with four lanes. A parameter selects a narrow build that is 18 bits wide with two lanes. A global write fills every lane. A byte write fills only the lanes whose select lines are low. When neither control is asserted the cycle is a read.

Top module: `lane_write_decoder`

## Requirements
- R1: All controls, the address and the data are captured on the rising clock edge, and the outputs show them from that edge onward, never earlier. While reset is low, `laneWrEn`, `wrValid` and `bitWrMask` are all zero.
- R2: With `globalWrN` low, every bit of `laneWrEn` is 1, whatever `byteWrEnN` and `laneSelN` hold.
- R3: With `globalWrN` high and `byteWrEnN` low, `laneWrEn[k]` is 1 exactly when `laneSelN[k]` is 0. Any mix of one to all lanes is possible.
- R4: With `globalWrN` and `byteWrEnN` both high, `laneWrEn` is all zero whatever the selects hold.
- R5: `wrValid` is 1 exactly when at least one bit of `laneWrEn` is 1. A byte write with no lane selected leaves it at 0.
- R6: `addrOut` and `dataOut` carry the `addrIn` and `dataIn` sampled on the same edge as the controls behind `laneWrEn`.
- R7: Bit i of `bitWrMask` equals `laneWrEn[i/9]`. An array written through this mask keeps the old contents of every lane that is not enabled.
- R8: With `WIDE` = 0 the block is 18 bits wide with two 9-bit lanes, and R2 to R7 hold for two lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| globalWrN | input | 1 | Global write, active low; writes all lanes |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| laneSelN | input | LANES | Per-lane select, active low |
| addrIn | input | ADDR_W | Address to register |
| dataIn | input | LANES*9 | Write data to register |
| laneWrEn | output | LANES | Registered per-lane write enables |
| wrValid | output | 1 | A write to at least one lane is under way |
| bitWrMask | output | LANES*9 | Per-bit write mask for the array |
| addrOut | output | ADDR_W | Registered address |
| dataOut | output | LANES*9 | Registered write data |

## Verification
The assertions assume that every control input holds a defined 0 or 1 at each sampling edge after reset is released. They also assume that reset spans at least one clock edge, so that every `$past` value comes from a real capture. The bench changes the inputs only on falling edges and always drives defined values. It parks the controls in the read state before it releases reset, so the first captured cycle is a known read. It then walks all 64 combinations of the controls in both builds.

// File: rtl/lanewr_pkg.sv
package lanewr_pkg;
  // Width of one byte lane: 8 data bits plus one parity bit.
  localparam int unsigned LANE_W    = 9;
  localparam int unsigned MAX_LANES = 4;

  // Strobes handed from the control decode to the datapath.
  typedef struct packed {
    logic [MAX_LANES-1:0] laneEn;
    logic                 valid;
  } wrStrobe_t;
endpackage

// File: rtl/lanewr_ctrl.sv
module lanewr_ctrl
  import lanewr_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             globalWrN,
  input  logic             byteWrEnN,
  input  logic [LANES-1:0] laneSelN,
  output wrStrobe_t        strobe
);

  // Input register stage: the reset value is the inactive (high) level.
  logic             gwQ;
  logic             bweQ;
  logic [LANES-1:0] selQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gwQ  <= 1'b1;
      bweQ <= 1'b1;
      selQ <= '1;
    end else begin
      gwQ  <= globalWrN;
      bweQ <= byteWrEnN;
      selQ <= laneSelN;
    end
  end

  // Decode: a global write wins, then a byte write, else a read.
  logic [MAX_LANES-1:0] laneDec;

  always_comb begin
    laneDec = '0;
    if (!gwQ) begin
      laneDec[LANES-1:0] = '1;
    end else if (!bweQ) begin
      laneDec[LANES-1:0] = ~selQ;
    end
  end

  always_comb begin
    strobe.laneEn = laneDec;
    strobe.valid  = |laneDec;
  end

  // Global write enables every lane one cycle later.
  assert_global_all_R2: assert property (@(posedge clk) disable iff (!rstN)
    !globalWrN |=> (strobe.laneEn[LANES-1:0] == {LANES{1'b1}}));

  // Byte write follows the inverted selects of the sampled cycle.
  assert_byte_sel_R3: assert property (@(posedge clk) disable iff (!rstN)
    (globalWrN && !byteWrEnN) |=> (strobe.laneEn[LANES-1:0] == ~$past(laneSelN)));

  // A read cycle enables nothing.
  assert_read_none_R4: assert property (@(posedge clk) disable iff (!rstN)
    (globalWrN && byteWrEnN) |=> (strobe.laneEn == '0));

endmodule

// File: rtl/lanewr_dpath.sv
module lanewr_dpath
  import lanewr_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wrStrobe_t               strobe,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES-1:0]        laneWrEn,
  output logic                    wrValid,
  output logic [LANES*LANE_W-1:0] bitWrMask,
  output logic [ADDR_W-1:0]       addrOut,
  output logic [LANES*LANE_W-1:0] dataOut
);

  localparam int unsigned DATA_W = LANES * LANE_W;

  // Address and data registers, captured on the same edge as the controls.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrOut <= '0;
      dataOut <= '0;
    end else begin
      addrOut <= addrIn;
      dataOut <= dataIn;
    end
  end

  assign laneWrEn = strobe.laneEn[LANES-1:0];
  assign wrValid  = strobe.valid;

  // Expand each lane enable across the bits of its lane.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign bitWrMask[k*LANE_W +: LANE_W] = {LANE_W{laneWrEn[k]}};
  end

  // Unused lanes of the strobe struct must stay quiet in the narrow build.
  if (LANES < MAX_LANES) begin : g_unused
    assert_unused_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
      strobe.laneEn[MAX_LANES-1:LANES] == '0);
  end

  // The valid flag and the mask agree.
  assert_valid_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrValid == (bitWrMask != {DATA_W{1'b0}}));

  // Address and data move with the controls.
  assert_addr_data_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (addrOut == $past(addrIn)) && (dataOut == $past(dataIn)));

endmodule

// File: rtl/lane_write_decoder.sv
module lane_write_decoder
  import lanewr_pkg::*;
#(
  parameter bit          WIDE   = 1'b1,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned LANES  = WIDE ? 4 : 2,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  laneSelN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [LANES-1:0]  laneWrEn,
  output logic              wrValid,
  output logic [DATA_W-1:0] bitWrMask,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut
);

  wrStrobe_t strobe;

  lanewr_ctrl #(.LANES(LANES)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .globalWrN (globalWrN),
    .byteWrEnN (byteWrEnN),
    .laneSelN  (laneSelN),
    .strobe    (strobe)
  );

  lanewr_dpath #(.LANES(LANES), .ADDR_W(ADDR_W)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .addrIn    (addrIn),
    .dataIn    (dataIn),
    .laneWrEn  (laneWrEn),
    .wrValid   (wrValid),
    .bitWrMask (bitWrMask),
    .addrOut   (addrOut),
    .dataOut   (dataOut)
  );

endmodule

// File: tb/test_lane_write_decoder.sv
module test_lane_write_decoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  // Wide build signals
  logic        gwN, bweN;
  logic [3:0]  selN;
  logic [3:0]  addrIn;
  logic [35:0] dataIn;
  logic [3:0]  laneWrEn;
  logic        wrValid;
  logic [35:0] bitWrMask, dataOut;
  logic [3:0]  addrOut;

  // Narrow build signals
  logic [17:0] nBitWrMask, nDataOut;
  logic [1:0]  nLaneWrEn;
  logic        nWrValid;
  logic [3:0]  nAddrOut;

  lane_write_decoder i_lane_write_decoder (
    .clk(clk), .rstN(rstN), .globalWrN(gwN), .byteWrEnN(bweN), .laneSelN(selN),
    .addrIn(addrIn), .dataIn(dataIn), .laneWrEn(laneWrEn), .wrValid(wrValid),
    .bitWrMask(bitWrMask), .addrOut(addrOut), .dataOut(dataOut));

  lane_write_decoder #(.WIDE(1'b0)) i_lane_write_decoder_narrow (
    .clk(clk), .rstN(rstN), .globalWrN(gwN), .byteWrEnN(bweN), .laneSelN(selN[1:0]),
    .addrIn(addrIn), .dataIn(dataIn[17:0]), .laneWrEn(nLaneWrEn), .wrValid(nWrValid),
    .bitWrMask(nBitWrMask), .addrOut(nAddrOut), .dataOut(nDataOut));

  int compared = 0;
  int mismatched = 0;

  // Table entries: {gwN, bweN, selN[3:0], expected lanes[3:0]}
  localparam logic [9:0] VEC [10] = '{
    10'b11_0000_0000,  // read with all selects low (R4)
    10'b01_1111_1111,  // global write (R2)
    10'b00_1010_1111,  // global overrides byte selects (R2)
    10'b10_1110_0001,  // single lane 0 (R3)
    10'b10_0111_1000,  // single lane 3 (R3)
    10'b10_1001_0110,  // two middle lanes (R3)
    10'b10_0001_1110,  // three lanes (R3)
    10'b10_0000_1111,  // all four by select (R3)
    10'b10_1111_0000,  // byte enable but no lane (R5)
    10'b11_1010_0000   // read with some selects low (R4)
  };

  logic [35:0] dutMem [4];
  logic [35:0] refMem [4];
  logic [17:0] nDutMem [4];
  logic [17:0] nRefMem [4];

  function automatic logic [3:0] refDecode(logic g, logic b, logic [3:0] s, int nl);
    logic [3:0] r;
    if (!g)      r = 4'b1111;
    else if (!b) r = ~s;
    else         r = 4'b0000;
    if (nl == 2) r[3:2] = 2'b00;
    return r;
  endfunction

  function automatic logic [35:0] expandMask(logic [3:0] l);
    logic [35:0] m;
    for (int i = 0; i < 36; i++) m[i] = l[i/9];
    return m;
  endfunction

  task automatic checkVal(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, then check at the next falling edge.
  task automatic runCycle(logic g, logic b, logic [3:0] s, logic [3:0] a,
                          logic [35:0] d, logic [3:0] expWide);
    logic [3:0]  expNar;
    logic [35:0] m;
    logic [17:0] nm;
    gwN = g; bweN = b; selN = s; addrIn = a; dataIn = d;
    expNar = refDecode(g, b, s, 2);
    @(negedge clk);
    checkVal("R2/R3/R4 wide laneWrEn", 64'(laneWrEn), 64'(expWide));
    checkVal("R5 wide wrValid", 64'(wrValid), 64'(|expWide));
    checkVal("R7 wide bitWrMask", 64'(bitWrMask), 64'(expandMask(expWide)));
    checkVal("R6 wide addrOut", 64'(addrOut), 64'(a));
    checkVal("R6 wide dataOut", 64'(dataOut), 64'(d));
    checkVal("R8 narrow laneWrEn", 64'(nLaneWrEn), 64'(expNar[1:0]));
    checkVal("R8 narrow wrValid", 64'(nWrValid), 64'(|expNar));
    checkVal("R8 narrow bitWrMask", 64'(nBitWrMask), 64'(expandMask(expNar) & 36'h3FFFF));
    checkVal("R8 narrow dataOut", 64'(nDataOut), 64'(d[17:0]));
    // Array models: one written through the outputs, one from the requirements.
    if (wrValid)
      dutMem[addrOut] = (dutMem[addrOut] & ~bitWrMask) | (dataOut & bitWrMask);
    if (nWrValid)
      nDutMem[nAddrOut] = (nDutMem[nAddrOut] & ~nBitWrMask) | (nDataOut & nBitWrMask);
    m  = expandMask(expWide);
    nm = expandMask(expNar) & 36'h3FFFF;
    refMem[a[1:0]]  = (refMem[a[1:0]] & ~m) | (d & m);
    nRefMem[a[1:0]] = (nRefMem[a[1:0]] & ~nm) | (d[17:0] & nm);
    checkVal("R7 wide array lanes kept", 64'(dutMem[a[1:0]]), 64'(refMem[a[1:0]]));
    checkVal("R8 narrow array lanes kept", 64'(nDutMem[a[1:0]]), 64'(nRefMem[a[1:0]]));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      dutMem[i] = '0; refMem[i] = '0; nDutMem[i] = '0; nRefMem[i] = '0;
    end
    // Controls request a global write while reset is held.
    gwN = 1'b0; bweN = 1'b0; selN = 4'h0; addrIn = 4'h5; dataIn = 36'hFFFFFFFFF;
    repeat (3) @(negedge clk);
    checkVal("R1 reset laneWrEn", 64'(laneWrEn), 64'h0);
    checkVal("R1 reset wrValid", 64'(wrValid), 64'h0);
    checkVal("R1 reset bitWrMask", 64'(bitWrMask), 64'h0);
    checkVal("R1 reset narrow laneWrEn", 64'(nLaneWrEn), 64'h0);
    gwN = 1'b1; bweN = 1'b1; selN = 4'hF; addrIn = 4'h0; dataIn = '0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: a write driven now must not show before the rising edge.
    gwN = 1'b0; addrIn = 4'h1; dataIn = 36'h123456789;
    #2;
    checkVal("R1 no early laneWrEn", 64'(laneWrEn), 64'h0);
    checkVal("R1 no early addrOut", 64'(addrOut), 64'h0);
    @(negedge clk);
    checkVal("R1 laneWrEn after edge", 64'(laneWrEn), 64'hF);
    gwN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      dutMem[i] = '0; refMem[i] = '0; nDutMem[i] = '0; nRefMem[i] = '0;
    end
    // Fill every row with a known pattern via global writes.
    for (int i = 0; i < 4; i++)
      runCycle(1'b0, 1'b1, 4'hF, 4'(i), 36'hA5A5A5A5A ^ 36'(i * 7), 4'hF);
    // Table walk
    for (int i = 0; i < 10; i++)
      runCycle(VEC[i][9], VEC[i][8], VEC[i][7:4], 4'(i % 4),
               {4'(i), 32'($urandom)}, VEC[i][3:0]);
    // Every control combination against the reference decode
    for (int c = 0; c < 64; c++) begin
      logic [5:0] cc;
      cc = 6'(c);
      runCycle(cc[5], cc[4], cc[3:0], 4'(c % 4), {4'(c), 32'($urandom)},
               refDecode(cc[5], cc[4], cc[3:0], 4));
    end
    // Reset in the middle of a write clears the enables (R1).
    gwN = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkVal("R1 mid-run reset laneWrEn", 64'(laneWrEn), 64'h0);
    checkVal("R1 mid-run reset wrValid", 64'(wrValid), 64'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule